// File: doc/BRIEF.md
# Voice Playback Trigger Option Handler

This block sits between the debounced trigger pins of a voice playback device and its audio engine. It watches a small bank of key inputs, or, in parallel-address mode, an address bus and a strobe. It turns their activity into start and stop commands for one playback channel. Every group carries its own option set: edge or level trigger, holdable or unholdable, retriggerable or not, and a stop-pulse enable. An external group lookup supplies these options when a trigger event is presented.

All durations are counted in ticks of an input `tick`. The default parameters assume a tick period of half a millisecond, so a bench can run on a scaled tick. One input picks the long or the short timing set for the whole block. A trigger change that arrives while playback is active must stay stable for longer than one that arrives while the channel is idle. When playback ends, a stop pulse is raised if that group enables it. A `halt` input stops playback at once.

Top module: `voice_trig_opt`

## Requirements
- R1: While reset is asserted and after it is released, with no stimulus, `play_start`, `play_stop` and `stop_pulse` are 0 and `play_grp` is 0.
- R2: An input change is accepted only after it has held its new value on DB_SHORT=2 ticks (short set) or DB_LONG=32 ticks (long set) while idle. With a tick on every cycle, `play_start` is seen L+2 cycles after a key rises, where L is the applicable limit. A pulse shorter than L is ignored.
- R3: While playing, the acceptance limit is DB_SHORT_BUSY=3 (short set) or DB_LONG_BUSY=48 (long set) ticks. This applies to releases and to new triggers alike.
- R4: With `par_mode`=1, a debounced rising edge on `strobe` starts group `addr_in`+1, with `addr_in[7]` as the MSB. The key inputs are ignored in this mode.
- R5: With `par_mode`=0, key i selects group i+1. When several keys are accepted in the same cycle, the lowest index wins.
- R6: Option bits on `opt_in` are [3]=edge trigger, [2]=holdable, [1]=retriggerable, [0]=stop pulse enable. A level-holdable group raises `play_stop` when its trigger release is accepted.
- R7: An unholdable group ignores release of its trigger and plays until `play_done`, which ends it without `play_stop`.
- R8: For a retriggerable group that is not edge-holdable, a new accepted trigger during playback raises `play_start` again and loads the new group.
- R9: For a non-retriggerable group, a new trigger during playback raises neither strobe and leaves `play_grp` unchanged.
- R10: For an edge-holdable group, a second accepted trigger during playback raises `play_stop` and ends playback.
- R11: When playback ends by any path other than `halt`, and the captured option [0] is set, `stop_pulse` rises in the next cycle. It lasts SP_SHORT=1 tick (short set) or SP_LONG=256 ticks (long set). With option [0] clear no pulse appears, and a new `play_start` clears a running pulse.
- R12: `halt`=1 raises `play_stop` in the next cycle if playing, clears any stop pulse, produces no stop pulse, and causes triggers accepted while it is high to be ignored.
- R13: Debounce and stop-pulse counters advance only in cycles with `tick`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timing tick, one cycle wide |
| long_sel | input | 1 | 1 selects the long timing set |
| par_mode | input | 1 | 1 selects parallel-address triggering |
| halt | input | 1 | Immediate stop, active high |
| key_in | input | NUM_KEYS | Raw key trigger lines |
| strobe | input | 1 | Raw address strobe |
| addr_in | input | ADDR_W | Group address for parallel mode |
| opt_in | input | 4 | Options of the group shown on `look_grp` |
| play_done | input | 1 | Audio engine finished the group |
| look_grp | output | ADDR_W+1 | Group of the current trigger event, for option lookup |
| play_start | output | 1 | One-cycle start command |
| play_stop | output | 1 | One-cycle stop command |
| play_grp | output | ADDR_W+1 | Group being played (1-based) |
| stop_pulse | output | 1 | End-of-playback pulse |

## Verification
A trigger change reaches `play_start` or `play_stop` L+2 cycles after it is driven. That is one input register, L tick counts in the debouncer, and the controller register. `halt` and `play_done` act one cycle after they are driven. `stop_pulse` rises in that same cycle and stays high for exactly its tick count. The bench records the cycle number of every strobe and pulse edge half a period after the clock. It compares those numbers with the stimulus cycle plus the expected latency, so every timing requirement is checked to the exact cycle. The parallel-address path is swept over all 256 addresses.

// File: rtl/vto_pkg.sv
package vto_pkg;
  // Per-group option set, bit order fixed by the opt_in port encoding
  typedef struct packed {
    logic edge_trig;  // [3]
    logic hold;       // [2]
    logic retrig;     // [1]
    logic stop_en;    // [0]
  } grp_opt_t;
endpackage

// File: rtl/vto_debounce.sv
module vto_debounce #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             raw,
  input  logic [CNT_W-1:0] limit,
  output logic             lvl,
  output logic             rise
);
  logic             raw_q;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             lvl_nx, rise_nx;

  always_comb begin
    cnt_nx  = cnt;
    lvl_nx  = lvl;
    rise_nx = 1'b0;
    if (raw_q == lvl) begin
      cnt_nx = '0;
    end else if (tick) begin
      if (cnt + 1'b1 >= limit) begin
        lvl_nx  = raw_q;
        rise_nx = raw_q;
        cnt_nx  = '0;
      end else begin
        cnt_nx = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      lvl   <= 1'b0;
      rise  <= 1'b0;
      cnt   <= '0;
    end else begin
      raw_q <= raw;
      lvl   <= lvl_nx;
      rise  <= rise_nx;
      cnt   <= cnt_nx;
    end
  end

  AST_LVL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl) |-> $past(tick)); // R13
  AST_RISE_IS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (lvl && !$past(lvl))); // R2
endmodule

// File: rtl/vto_source.sv
module vto_source #(
  parameter int NUM_KEYS = 4,
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 6,
  parameter int GRP_W    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                par_mode,
  input  logic [NUM_KEYS-1:0] key_in,
  input  logic                strobe,
  input  logic [ADDR_W-1:0]   addr_in,
  input  logic [CNT_W-1:0]    limit,
  input  logic [GRP_W-1:0]    cur_grp,
  output logic                ev_rise,
  output logic [GRP_W-1:0]    ev_grp,
  output logic                held
);
  logic [NUM_KEYS-1:0] key_lvl, key_rise;
  logic                stb_lvl, stb_rise;
  logic [GRP_W-1:0]    key_grp;
  logic                key_held;

  generate
    for (genvar gi = 0; gi < NUM_KEYS; gi++) begin : g_key
      vto_debounce #(.CNT_W(CNT_W)) u_db (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .raw   (key_in[gi]),
        .limit (limit),
        .lvl   (key_lvl[gi]),
        .rise  (key_rise[gi])
      );
    end
  endgenerate

  vto_debounce #(.CNT_W(CNT_W)) u_stb (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .raw   (strobe),
    .limit (limit),
    .lvl   (stb_lvl),
    .rise  (stb_rise)
  );

  // Lowest accepted key wins; hold level follows the key of the playing group
  always_comb begin
    key_grp  = '0;
    key_held = 1'b0;
    for (int i = NUM_KEYS - 1; i >= 0; i--) begin
      if (key_rise[i]) key_grp = GRP_W'(i + 1);
    end
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (cur_grp == GRP_W'(i + 1)) key_held = key_lvl[i];
    end
  end

  always_comb begin
    if (par_mode) begin
      ev_rise = stb_rise;
      ev_grp  = GRP_W'(addr_in) + GRP_W'(1);
      held    = stb_lvl;
    end else begin
      ev_rise = |key_rise;
      ev_grp  = key_grp;
      held    = key_held;
    end
  end

  AST_KEY_GRP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && ev_rise) |-> (ev_grp >= GRP_W'(1) && ev_grp <= GRP_W'(NUM_KEYS))); // R5
endmodule

// File: rtl/vto_ctrl.sv
module vto_ctrl
  import vto_pkg::*;
#(
  parameter int GRP_W    = 9,
  parameter int SP_W     = 9,
  parameter int SP_SHORT = 1,
  parameter int SP_LONG  = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             long_sel,
  input  logic             halt,
  input  logic             play_done,
  input  logic             ev_rise,
  input  logic [GRP_W-1:0] ev_grp,
  input  grp_opt_t         ev_opt,
  input  logic             held,
  output logic             playing,
  output logic [GRP_W-1:0] cur_grp,
  output logic             play_start,
  output logic             play_stop,
  output logic             stop_pulse
);
  localparam logic [SP_W-1:0] SP_S = SP_W'(SP_SHORT);
  localparam logic [SP_W-1:0] SP_L = SP_W'(SP_LONG);

  grp_opt_t         cur_opt, opt_nx;
  logic             play_nx, start_nx, stop_nx, end_play, begin_play;
  logic [GRP_W-1:0] grp_nx;
  logic [SP_W-1:0]  sp_cnt, sp_nx;

  // Priority: halt, engine done, trigger event, hold release
  always_comb begin
    end_play   = 1'b0;
    begin_play = 1'b0;
    stop_nx    = 1'b0;
    if (halt) begin
      stop_nx = playing;
    end else if (playing && play_done) begin
      end_play = 1'b1;
    end else if (ev_rise) begin
      if (!playing) begin
        begin_play = 1'b1;
      end else if (cur_opt.edge_trig && cur_opt.hold) begin
        stop_nx  = 1'b1;
        end_play = 1'b1;
      end else if (cur_opt.retrig) begin
        begin_play = 1'b1;
      end
    end else if (playing && !cur_opt.edge_trig && cur_opt.hold && !held) begin
      stop_nx  = 1'b1;
      end_play = 1'b1;
    end
  end

  always_comb begin
    play_nx  = playing;
    grp_nx   = cur_grp;
    opt_nx   = cur_opt;
    start_nx = begin_play;
    sp_nx    = sp_cnt;
    if (sp_cnt != '0 && tick) sp_nx = sp_cnt - 1'b1;
    if (halt) begin
      play_nx = 1'b0;
      sp_nx   = '0;
    end
    if (begin_play) begin
      play_nx = 1'b1;
      grp_nx  = ev_grp;
      opt_nx  = ev_opt;
      sp_nx   = '0;
    end
    if (end_play) begin
      play_nx = 1'b0;
      if (cur_opt.stop_en) sp_nx = long_sel ? SP_L : SP_S;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      playing    <= 1'b0;
      cur_grp    <= '0;
      cur_opt    <= '0;
      play_start <= 1'b0;
      play_stop  <= 1'b0;
      sp_cnt     <= '0;
    end else begin
      playing    <= play_nx;
      cur_grp    <= grp_nx;
      cur_opt    <= opt_nx;
      play_start <= start_nx;
      play_stop  <= stop_nx;
      sp_cnt     <= sp_nx;
    end
  end

  assign stop_pulse = (sp_cnt != '0);

  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(play_start && play_stop)); // R10
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    play_start |-> playing); // R8
  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!playing && !stop_pulse)); // R12
  AST_PULSE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> !playing); // R11
  AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stop_pulse) && stop_pulse && !$stable(sp_cnt)) |-> $past(tick)); // R13
endmodule

// File: rtl/voice_trig_opt.sv
module voice_trig_opt
  import vto_pkg::*;
#(
  parameter int NUM_KEYS      = 4,
  parameter int ADDR_W        = 8,
  parameter int DB_SHORT      = 2,
  parameter int DB_SHORT_BUSY = 3,
  parameter int DB_LONG       = 32,
  parameter int DB_LONG_BUSY  = 48,
  parameter int SP_SHORT      = 1,
  parameter int SP_LONG       = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                long_sel,
  input  logic                par_mode,
  input  logic                halt,
  input  logic [NUM_KEYS-1:0] key_in,
  input  logic                strobe,
  input  logic [ADDR_W-1:0]   addr_in,
  input  logic [3:0]          opt_in,
  input  logic                play_done,
  output logic [ADDR_W:0]     look_grp,
  output logic                play_start,
  output logic                play_stop,
  output logic [ADDR_W:0]     play_grp,
  output logic                stop_pulse
);
  localparam int GRP_W = ADDR_W + 1;
  localparam int CNT_W = $clog2(DB_LONG_BUSY + 1);
  localparam int SP_W  = $clog2(SP_LONG + 1);
  localparam logic [CNT_W-1:0] LIM_S  = CNT_W'(DB_SHORT);
  localparam logic [CNT_W-1:0] LIM_SB = CNT_W'(DB_SHORT_BUSY);
  localparam logic [CNT_W-1:0] LIM_L  = CNT_W'(DB_LONG);
  localparam logic [CNT_W-1:0] LIM_LB = CNT_W'(DB_LONG_BUSY);

  logic [1:0]       rst_sync;
  logic             rst_n_i;
  logic             playing, ev_rise, held;
  logic [GRP_W-1:0] ev_grp, cur_grp;
  logic [CNT_W-1:0] limit;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  always_comb begin
    if (long_sel) limit = playing ? LIM_LB : LIM_L;
    else          limit = playing ? LIM_SB : LIM_S;
  end

  vto_source #(
    .NUM_KEYS (NUM_KEYS),
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .GRP_W    (GRP_W)
  ) u_src (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .tick     (tick),
    .par_mode (par_mode),
    .key_in   (key_in),
    .strobe   (strobe),
    .addr_in  (addr_in),
    .limit    (limit),
    .cur_grp  (cur_grp),
    .ev_rise  (ev_rise),
    .ev_grp   (ev_grp),
    .held     (held)
  );

  vto_ctrl #(
    .GRP_W    (GRP_W),
    .SP_W     (SP_W),
    .SP_SHORT (SP_SHORT),
    .SP_LONG  (SP_LONG)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .tick       (tick),
    .long_sel   (long_sel),
    .halt       (halt),
    .play_done  (play_done),
    .ev_rise    (ev_rise),
    .ev_grp     (ev_grp),
    .ev_opt     (grp_opt_t'(opt_in)),
    .held       (held),
    .playing    (playing),
    .cur_grp    (cur_grp),
    .play_start (play_start),
    .play_stop  (play_stop),
    .stop_pulse (stop_pulse)
  );

  assign look_grp = ev_grp;
  assign play_grp = cur_grp;

  AST_PAR_ADDR: assert property (@(posedge clk) disable iff (!rst_n_i)
    (par_mode && $past(par_mode) && play_start) |-> (play_grp == GRP_W'($past(addr_in)) + GRP_W'(1))); // R4
endmodule

// File: tb/voice_trig_opt_bench.sv
module voice_trig_opt_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, tick, long_sel, par_mode, halt, strobe, play_done;
  logic [3:0] keys, opt;
  logic [7:0] addr;
  logic [8:0] look_grp, play_grp;
  logic       play_start, play_stop, stop_pulse;

  int cyc = 0;
  int n_start = 0, n_stop = 0, n_sp = 0;
  int last_start = -1, last_stop = -1, last_grp = -1;
  int sp_on = -1, sp_len = -1;
  logic sp_prev = 1'b0;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  voice_trig_opt u_voice_trig_opt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .long_sel   (long_sel),
    .par_mode   (par_mode),
    .halt       (halt),
    .key_in     (keys),
    .strobe     (strobe),
    .addr_in    (addr),
    .opt_in     (opt),
    .play_done  (play_done),
    .look_grp   (look_grp),
    .play_start (play_start),
    .play_stop  (play_stop),
    .play_grp   (play_grp),
    .stop_pulse (stop_pulse)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (play_start) begin n_start++; last_start = cyc; last_grp = int'(play_grp); end
    if (play_stop)  begin n_stop++;  last_stop = cyc; end
    if (stop_pulse && !sp_prev) begin n_sp++; sp_on = cyc; end
    if (!stop_pulse && sp_prev) sp_len = cyc - sp_on;
    sp_prev = stop_pulse;
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic done_pulse();
    play_done = 1'b1; step(1); play_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
    finish_run();
  end

  initial begin
    int c, d, e, s0, st0, sp0;
    rst_n = 1'b0; tick = 1'b1; long_sel = 1'b0; par_mode = 1'b0; halt = 1'b0;
    strobe = 1'b0; play_done = 1'b0; keys = '0; opt = '0; addr = '0;
    step(3);
    chk(!play_start && !play_stop && !stop_pulse && play_grp == 0, "R1 in reset",
        int'({play_start, play_stop, stop_pulse}), 0);
    rst_n = 1'b1;
    step(6);
    chk(!play_start && !play_stop && !stop_pulse && play_grp == 0, "R1 after reset",
        int'(play_grp), 0);

    // R2 R5 R7 R11: edge, unholdable, stop pulse enabled
    opt = 4'b1001; c = cyc; s0 = n_start; keys[0] = 1'b1; step(8);
    chk(n_start == s0 + 1 && last_start == c + 4, "R2 idle debounce", last_start, c + 4);
    chk(last_grp == 1, "R5 key0 group", last_grp, 1);
    st0 = n_stop; keys[0] = 1'b0; step(8);
    chk(n_stop == st0, "R7 release ignored", n_stop, st0);
    c = cyc; done_pulse(); step(4);
    chk(sp_on == c + 1 && sp_len == 1, "R11 short stop pulse", sp_len, 1);
    chk(n_stop == st0, "R7 done without stop strobe", n_stop, st0);

    // R2 glitch rejection
    s0 = n_start; keys[1] = 1'b1; step(1); keys[1] = 1'b0; step(10);
    chk(n_start == s0, "R2 glitch ignored", n_start, s0);

    // R5 priority
    opt = 4'b1000; c = cyc; keys[1] = 1'b1; keys[2] = 1'b1; step(8);
    chk(last_start == c + 4 && last_grp == 2, "R5 lowest key wins", last_grp, 2);
    keys = '0; step(8); done_pulse(); step(4);

    // R6 R3 R11: level holdable, no stop pulse
    opt = 4'b0100; c = cyc; keys[2] = 1'b1; step(8);
    chk(last_grp == 3 && last_start == c + 4, "R6 level start", last_grp, 3);
    sp0 = n_sp; d = cyc; keys[2] = 1'b0; step(10);
    chk(last_stop == d + 5, "R3 busy release debounce", last_stop, d + 5);
    chk(n_sp == sp0, "R11 pulse disabled", n_sp, sp0);

    // R7 level unholdable
    opt = 4'b0001; st0 = n_stop; keys[0] = 1'b1; step(8); keys[0] = 1'b0; step(12);
    chk(n_stop == st0 && !stop_pulse, "R7 level unholdable keeps playing", n_stop, st0);
    done_pulse(); step(4);

    // R8 R3 retrigger
    opt = 4'b1010; keys[0] = 1'b1; step(8); keys[0] = 1'b0; step(8);
    d = cyc; keys[3] = 1'b1; step(8);
    chk(last_start == d + 5 && last_grp == 4, "R8 retrigger restart", last_start, d + 5);
    keys[3] = 1'b0; step(8); done_pulse(); step(4);

    // R9 non-retriggerable
    opt = 4'b1000; keys[1] = 1'b1; step(8); keys[1] = 1'b0; step(8);
    opt = 4'b1010; s0 = n_start; st0 = n_stop; keys[2] = 1'b1; step(10);
    chk(n_start == s0 && n_stop == st0, "R9 trigger ignored", n_start, s0);
    chk(play_grp == 2, "R9 group kept", int'(play_grp), 2);
    keys[2] = 1'b0; step(8); done_pulse(); step(4);

    // R10 edge holdable
    opt = 4'b1100; keys[0] = 1'b1; step(8); keys[0] = 1'b0; step(8);
    d = cyc; keys[0] = 1'b1; step(8);
    chk(last_stop == d + 5, "R10 second trigger stops", last_stop, d + 5);
    keys[0] = 1'b0; step(8);

    // R12 halt
    opt = 4'b0001; s0 = n_start; keys[1] = 1'b1; step(8);
    sp0 = n_sp; c = cyc; halt = 1'b1; step(3);
    chk(last_stop == c + 1, "R12 halt stops next cycle", last_stop, c + 1);
    chk(n_sp == sp0 && !stop_pulse, "R12 no stop pulse", n_sp, sp0);
    keys[1] = 1'b0; step(6); s0 = n_start; keys[2] = 1'b1; step(8);
    chk(n_start == s0, "R12 trigger during halt ignored", n_start, s0);
    halt = 1'b0; step(8);
    chk(n_start == s0, "R12 no late start", n_start, s0);
    keys[2] = 1'b0; step(8);

    // R13 tick gating
    opt = 4'b1000; tick = 1'b0; s0 = n_start; keys[0] = 1'b1; step(30);
    chk(n_start == s0, "R13 no tick no accept", n_start, s0);
    c = cyc; tick = 1'b1; step(6);
    chk(last_start == c + 3, "R13 accept on ticks", last_start, c + 3);
    keys[0] = 1'b0; step(8); done_pulse(); step(4);

    // Long timing set: R2 R3 R11
    long_sel = 1'b1; opt = 4'b1001; c = cyc; keys[0] = 1'b1; step(40);
    chk(last_start == c + 34, "R2 long debounce", last_start, c + 34);
    keys[0] = 1'b0; step(60);
    d = cyc; done_pulse(); step(262);
    chk(sp_on == d + 1 && sp_len == 256, "R11 long stop pulse", sp_len, 256);
    opt = 4'b0100; keys[1] = 1'b1; step(40);
    d = cyc; keys[1] = 1'b0; step(60);
    chk(last_stop == d + 50, "R3 long busy debounce", last_stop, d + 50);
    opt = 4'b1001; keys[2] = 1'b1; step(40); keys[2] = 1'b0; step(60);
    done_pulse(); step(20);
    chk(stop_pulse == 1'b1, "R11 long pulse running", int'(stop_pulse), 1);
    e = cyc; keys[3] = 1'b1; step(40);
    chk(last_start == e + 34 && !stop_pulse, "R11 start clears pulse", int'(stop_pulse), 0);
    keys[3] = 1'b0; step(60); done_pulse(); long_sel = 1'b0; step(270);

    // R4 parallel mode: keys ignored, then all addresses
    par_mode = 1'b1; opt = 4'b1000; s0 = n_start; keys[0] = 1'b1; step(10);
    chk(n_start == s0, "R4 keys ignored", n_start, s0);
    keys[0] = 1'b0; step(8);
    for (int a = 0; a < 256; a++) begin
      addr = 8'(a); c = cyc; strobe = 1'b1; step(6);
      chk(last_start == c + 4 && last_grp == a + 1, "R4 address latch", last_grp, a + 1);
      strobe = 1'b0; done_pulse(); step(7);
    end

    finish_run();
  end
endmodule